// File: doc/BRIEF.md
# Signed 24-bit ALU with Status Flags

This block is a purely combinational arithmetic and logic unit for 24-bit two's-complement integers. A 4-bit select picks one operation on operands `a` and `b`. The main result appears on `r0`. For multiplication, `r1` carries the upper half of the 48-bit product. Five flags describe the result: sign, zero, even parity, carry and overflow. The carry and overflow flags follow a rule that depends on the operation. A separate `div_err` output reports a zero divisor.

An execution stage places the block between its operand fetch and its writeback. The stage reads `r0` and `r1` in the same cycle. It raises `valid` to capture the flags into the registered `flags_q` at the next clock edge. The parameter `REG_FLAGS` set to 0 makes `flags_q` follow the live flags with no register.

Top module: `alu24_flags`

## Requirements
- R1: With op code 0 (add), `r0` = (a + b) mod 2^24. `f_carry` is the carry out of bit 23. `f_ovf` is 1 when `a` and `b` have the same sign and `r0` has the other sign.
- R2: With op code 1 (subtract), `r0` = (a − b) mod 2^24. `f_carry` is 1 when unsigned `a` is less than unsigned `b` (a borrow). `f_ovf` is 1 when `a` and `b` differ in sign and the sign of `r0` differs from the sign of `a`.
- R3: Op code 2 (increment) and op code 3 (decrement) ignore `b` and use 1 in its place. They follow the add and subtract flag rules of R1 and R2.
- R4: With op code 4 (multiply), `r0` holds bits 23:0 of the signed 48-bit product and `r1` holds bits 47:24. `f_carry` and `f_ovf` are both 0 when every bit of `r1` equals `r0[23]`, and both 1 otherwise.
- R5: Op code 5 (divide) truncates the quotient toward zero. Op code 6 (modulo) gives a remainder that has the sign of `a`. The case −2^23 ÷ −1 gives a quotient of −2^23 (800000h) and a remainder of 0. Both operations clear `f_carry` and `f_ovf`.
- R6: Divide or modulo with `b` = 0 gives `r0` = 0 and `div_err` = 1. `div_err` is 0 in every other case.
- R7: Op codes 7, 8 and 9 give bitwise AND, OR and XOR of `a` and `b`. Op code 10 gives the bitwise NOT of `a`. All four clear `f_carry` and `f_ovf`.
- R8: Op codes 11 to 15 pass `a` to `r0` unchanged and clear `f_carry` and `f_ovf`.
- R9: `r1` is 0 for every op code except 4.
- R10: The sign, zero and even flags are always computed from `r0`. `f_sign` = `r0[23]`. `f_zero` is 1 when `r0` = 0. `f_even` is 1 when `r0` has an even number of 1 bits.
- R11: `flags_q` packs the flags as {sign, zero, even, carry, ovf}, with sign at bit 4 and ovf at bit 0. With `REG_FLAGS` = 1, reset clears it to 0. A rising clock with `valid` high loads it from the live flags. A rising clock with `valid` low leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Load strobe for `flags_q` |
| op | input | 4 | Operation select |
| a | input | 24 | First operand |
| b | input | 24 | Second operand |
| r0 | output | 24 | Result, or low half of the product |
| r1 | output | 24 | High half of the product, otherwise 0 |
| f_sign | output | 1 | Result is negative |
| f_zero | output | 1 | Result is zero |
| f_even | output | 1 | Result has even parity |
| f_carry | output | 1 | Carry, borrow or product spill |
| f_ovf | output | 1 | Signed overflow |
| div_err | output | 1 | Divide or modulo by zero |
| flags_q | output | 5 | Registered flags {sign, zero, even, carry, ovf} |

## Verification
A table of hand-worked vectors covers the boundaries of each operation. For addition and subtraction it uses a carry with no overflow and an overflow with no carry, which tells the two flag rules apart. For multiplication it uses one product that fits in 24 bits and one that spills, and for division it uses mixed signs, a zero divisor and the most-negative ÷ −1 case. Random operands, biased toward 0, ±1 and the two signed extremes, are then compared against an arithmetic model on wide integers. In that model the carry and overflow come from a range test, not from bit patterns. Directed clock tests then separate a loaded `flags_q` from a held one.

// File: rtl/alu24_flags.sv
module alu24_flags #(
  parameter int W = 24,
  parameter bit REG_FLAGS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r0,
  output logic [W-1:0] r1,
  output logic         f_sign,
  output logic         f_zero,
  output logic         f_even,
  output logic         f_carry,
  output logic         f_ovf,
  output logic         div_err,
  output logic [4:0]   flags_q
);

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_INC = 4'd2;
  localparam logic [3:0] OP_DEC = 4'd3;
  localparam logic [3:0] OP_MUL = 4'd4;
  localparam logic [3:0] OP_DIV = 4'd5;
  localparam logic [3:0] OP_MOD = 4'd6;
  localparam logic [3:0] OP_AND = 4'd7;
  localparam logic [3:0] OP_OR  = 4'd8;
  localparam logic [3:0] OP_XOR = 4'd9;
  localparam logic [3:0] OP_NOT = 4'd10;

  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] bo;
  logic [W:0]   sum, diff;
  logic signed [2*W-1:0] prod;
  logic signed [W-1:0]   quo, rem;
  logic         b_zero;

  assign bo   = (op == OP_INC || op == OP_DEC) ? ONE : b;
  assign sum  = {1'b0, a} + {1'b0, bo};
  assign diff = {1'b0, a} - {1'b0, bo};
  assign prod = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
  assign b_zero = (b == '0);

  always_comb begin
    if (b_zero) begin
      quo = '0;
      rem = '0;
    end else if (a == SMIN && b == '1) begin
      quo = $signed(SMIN);
      rem = '0;
    end else begin
      quo = $signed(a) / $signed(b);
      rem = $signed(a) % $signed(b);
    end
  end

  always_comb begin
    r0      = a;
    r1      = '0;
    f_carry = 1'b0;
    f_ovf   = 1'b0;
    div_err = 1'b0;
    unique case (op)
      OP_ADD, OP_INC: begin
        r0      = sum[W-1:0];
        f_carry = sum[W];
        f_ovf   = (a[W-1] == bo[W-1]) && (sum[W-1] != a[W-1]);
      end
      OP_SUB, OP_DEC: begin
        r0      = diff[W-1:0];
        f_carry = diff[W];
        f_ovf   = (a[W-1] != bo[W-1]) && (diff[W-1] != a[W-1]);
      end
      OP_MUL: begin
        r0      = prod[W-1:0];
        r1      = prod[2*W-1:W];
        f_carry = (prod[2*W-1:W] != {W{prod[W-1]}});
        f_ovf   = f_carry;
      end
      OP_DIV: begin
        r0      = quo;
        div_err = b_zero;
      end
      OP_MOD: begin
        r0      = rem;
        div_err = b_zero;
      end
      OP_AND: r0 = a & b;
      OP_OR:  r0 = a | b;
      OP_XOR: r0 = a ^ b;
      OP_NOT: r0 = ~a;
      default: r0 = a;
    endcase
  end

  assign f_sign = r0[W-1];
  assign f_zero = ~|r0;
  assign f_even = ~^r0;

  generate
    if (REG_FLAGS) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flags_q <= '0;
        else if (valid) flags_q <= {f_sign, f_zero, f_even, f_carry, f_ovf};
      end

      a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> flags_q == $past({f_sign, f_zero, f_even, f_carry, f_ovf}));
      a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(flags_q));
    end else begin : g_comb
      assign flags_q = {f_sign, f_zero, f_even, f_carry, f_ovf};
    end
  endgenerate

  a_r4_mul_flags_match: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_MUL |-> f_carry == f_ovf);
  a_r6_div_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> (r0 == '0 && b == '0 && (op == OP_DIV || op == OP_MOD)));
  a_r7_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= OP_AND) |-> !f_carry && !f_ovf);
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    op != OP_MUL |-> r1 == '0);
  a_r5_div_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DIV || op == OP_MOD) |-> !f_carry && !f_ovf);

endmodule

// File: tb/alu24_flags_tb.sv
module alu24_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [23:0] a = '0, b = '0;
  logic [23:0] r0, r1;
  logic        f_sign, f_zero, f_even, f_carry, f_ovf, div_err;
  logic [4:0]  flags_q;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu24_flags u_dut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .a(a), .b(b),
    .r0(r0), .r1(r1), .f_sign(f_sign), .f_zero(f_zero), .f_even(f_even),
    .f_carry(f_carry), .f_ovf(f_ovf), .div_err(div_err), .flags_q(flags_q)
  );

  // {op, a, b, r0, r1, flags{sign,zero,even,carry,ovf}, div_err}
  localparam int NV = 19;
  localparam logic [105:0] VEC [NV] = '{
    {4'd0,  24'h000005, 24'h000003, 24'h000008, 24'h000000, 5'b00000, 1'b0},
    {4'd0,  24'h7FFFFF, 24'h000001, 24'h800000, 24'h000000, 5'b10001, 1'b0},
    {4'd0,  24'hFFFFFF, 24'h000001, 24'h000000, 24'h000000, 5'b01110, 1'b0},
    {4'd1,  24'h000003, 24'h000005, 24'hFFFFFE, 24'h000000, 5'b10010, 1'b0},
    {4'd1,  24'h800000, 24'h000001, 24'h7FFFFF, 24'h000000, 5'b00001, 1'b0},
    {4'd2,  24'h7FFFFF, 24'h123456, 24'h800000, 24'h000000, 5'b10001, 1'b0},
    {4'd3,  24'h000000, 24'h123456, 24'hFFFFFF, 24'h000000, 5'b10110, 1'b0},
    {4'd4,  24'h000003, 24'hFFFFFE, 24'hFFFFFA, 24'hFFFFFF, 5'b10100, 1'b0},
    {4'd4,  24'h001000, 24'h001000, 24'h000000, 24'h000001, 5'b01111, 1'b0},
    {4'd5,  24'hFFFFF9, 24'h000002, 24'hFFFFFD, 24'h000000, 5'b10000, 1'b0},
    {4'd6,  24'hFFFFF9, 24'h000002, 24'hFFFFFF, 24'h000000, 5'b10100, 1'b0},
    {4'd5,  24'h000007, 24'h000000, 24'h000000, 24'h000000, 5'b01100, 1'b1},
    {4'd5,  24'h800000, 24'hFFFFFF, 24'h800000, 24'h000000, 5'b10000, 1'b0},
    {4'd7,  24'hF0F0F0, 24'h0FF0FF, 24'h00F0F0, 24'h000000, 5'b00100, 1'b0},
    {4'd8,  24'h0F0000, 24'h0000F0, 24'h0F00F0, 24'h000000, 5'b00100, 1'b0},
    {4'd9,  24'hAAAAAA, 24'h555555, 24'hFFFFFF, 24'h000000, 5'b10100, 1'b0},
    {4'd10, 24'h000000, 24'h123456, 24'hFFFFFF, 24'h000000, 5'b10100, 1'b0},
    {4'd15, 24'h123456, 24'hFFFFFF, 24'h123456, 24'h000000, 5'b00000, 1'b0},
    {4'd6,  24'h000007, 24'hFFFFFE, 24'h000001, 24'h000000, 5'b00000, 1'b0}
  };

  function automatic string op_req(logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7, 4'd8, 4'd9, 4'd10: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [53:0] ref_model(logic [3:0] o, logic [23:0] x, logic [23:0] y);
    longint sa, sb, ua, ub, res;
    logic [23:0] q0, q1;
    logic c, v, d;
    sa = longint'($signed(x));
    sb = longint'($signed(y));
    ua = longint'(x);
    ub = longint'(y);
    if (o == 4'd2 || o == 4'd3) begin sb = 1; ub = 1; end
    c = 1'b0; v = 1'b0; d = 1'b0; q1 = '0; res = sa;
    case (o)
      4'd0, 4'd2: begin
        res = sa + sb;
        c = ((ua + ub) >= 64'sd16777216);
        v = (res > 8388607) || (res < -8388608);
      end
      4'd1, 4'd3: begin
        res = sa - sb;
        c = (ua < ub);
        v = (res > 8388607) || (res < -8388608);
      end
      4'd4: begin
        res = sa * sb;
        q1 = res[47:24];
        c = (res > 8388607) || (res < -8388608);
        v = c;
      end
      4'd5: if (sb == 0) begin res = 0; d = 1'b1; end else res = sa / sb;
      4'd6: if (sb == 0) begin res = 0; d = 1'b1; end else res = sa % sb;
      4'd7: res = ua & ub;
      4'd8: res = ua | ub;
      4'd9: res = ua ^ ub;
      4'd10: res = ~ua;
      default: res = ua;
    endcase
    q0 = res[23:0];
    return {q0, q1, q0[23], (q0 == 24'd0), ($countones(q0) % 2 == 0), c, v, d};
  endfunction

  task automatic check(string req, logic [53:0] act, logic [53:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] pick();
    case ($urandom_range(0, 7))
      0: return 24'h000000;
      1: return 24'h000001;
      2: return 24'hFFFFFF;
      3: return 24'h800000;
      4: return 24'h7FFFFF;
      5: return 24'(signed'($urandom_range(0, 40)) - 20);
      default: return 24'($urandom);
    endcase
  endfunction

  function automatic logic [53:0] outs();
    return {r0, r1, f_sign, f_zero, f_even, f_carry, f_ovf, div_err};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11: reset state
    check("R11", {49'd0, flags_q}, 54'd0, "flags_q in reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      op = VEC[i][105:102];
      a  = VEC[i][101:78];
      b  = VEC[i][77:54];
      #1;
      check(op_req(op), outs(), VEC[i][53:0], $sformatf("table vector %0d", i));
    end

    // R9 R10 R6 and all ops: random against model
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 120; k++) begin
        op = 4'(o);
        a = pick();
        b = pick();
        #1;
        check(op_req(op), outs(), ref_model(op, a, b),
              $sformatf("random op %0d a %h b %h (R9 R10 R6)", o, a, b));
      end
    end

    // R11: load on valid, hold without it
    @(negedge clk);
    op = 4'd0; a = 24'hFFFFFF; b = 24'h000001; valid = 1'b1;
    @(negedge clk);
    check("R11", {49'd0, flags_q}, {49'd0, 5'b01110}, "load with valid");
    valid = 1'b0; a = 24'h7FFFFF;
    @(negedge clk);
    check("R11", {49'd0, flags_q}, {49'd0, 5'b01110}, "hold without valid");
    valid = 1'b1;
    @(negedge clk);
    check("R11", {49'd0, flags_q}, {49'd0, 5'b10001}, "reload with valid");
    valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R11", {49'd0, flags_q}, 54'd0, "cleared by reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule